// File: doc/BRIEF.md
# Memory-Mapped Interval Timer

A 32-bit down-counter behind a small word-addressed register bus. Software sets a reload limit, picks periodic or single-shot operation and starts the counter. The count moves down by one on each cycle where the tick enable is high and the timer is running. When it steps from 1 to 0 the timer has expired. Expiry sets a sticky status bit. In periodic mode the count then reloads from the limit. In single-shot mode the timer stops. The interrupt line is a level: it is high while status and enable are both set.

Only address bits [11:2] select a register, so the block answers across a 4 KB window. Reads are combinational on the address. A write takes effect at the next clock edge. Two read-only words return a block identifier and the tick frequency; both are set by parameters, and the frequency must be nonzero. A prescaler, bus bridging and state save/restore are handled outside the block.

Top module: `tmr_interval_timer`

## Requirements
- R1: Word index = address bits [11:2]; other address bits are ignored. Index map: 0 identifier, 1 run, 2 mode (1 = single-shot), 3 limit, 4 count, 5 interrupt enable, 6 status, 7 frequency. Flag registers read back in bit 0 with upper bits zero. Reads of any other index return 0, and writes to them change no register.
- R2: Index 0 reads ID_VALUE and index 7 reads FREQ_HZ; writes to either leave every register unchanged.
- R3: A write to run stores wdata bit 0. Writing the value already held changes nothing. Writing 0 stops the count and keeps its value.
- R4: While running with tick high and count above 1, the count decreases by one per cycle; while stopped or with tick low it holds.
- R5: On expiry (running, tick high, count 1) status is set. In single-shot mode run clears and the count stays at 0.
- R6: On expiry in periodic mode the count reloads from the limit on that same tick and the timer keeps running.
- R7: A write to limit stores the value and loads it into the count at the same edge.
- R8: A write to count loads the count and leaves the limit unchanged.
- R9: A write to mode stores wdata bit 0. If the timer was running, the count reloads from the limit and the timer stays running, even on a cycle where single-shot expiry would have stopped it.
- R10: irq_o is high exactly when status and enable are both 1; a write to enable takes effect at the next edge.
- R11: Writing status with wdata bit 0 = 1 clears it, and writing 0 keeps it. An expiry in the same cycle wins and leaves status set.
- R12: Reset clears run, mode, limit, count, enable and status, and holds irq_o low.
- R13: A running timer with count 0 and tick high reloads the limit without setting status.
- R14: A bus write to limit, count, or mode-while-running sets the count, overriding the tick update of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable, one decrement per high cycle |
| bus_addr_i | input | ADDR_W | Byte address; bits [11:2] select the word |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the addressed word |
| irq_o | output | 1 | Level interrupt |

## Verification
Assertions check every cycle that single-shot expiry halts at zero with status set, that periodic expiry reloads the limit, that a stopped count holds, and that a limit write loads both registers. They also check that zero-count reload leaves status alone, that write-one-to-clear works, and that the interrupt follows its enable. Only the bench shows the full register map under address aliasing, the ignored writes to read-only and unmapped words, and mode changes while running. It also shows the priority of bus writes over ticks and the reset state, by comparing every read and the interrupt against a reference model driven by seeded random traffic and directed sequences.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned IDX_W = 10;

  localparam logic [IDX_W-1:0] IDX_ID    = 10'd0;
  localparam logic [IDX_W-1:0] IDX_RUN   = 10'd1;
  localparam logic [IDX_W-1:0] IDX_MODE  = 10'd2;
  localparam logic [IDX_W-1:0] IDX_LIMIT = 10'd3;
  localparam logic [IDX_W-1:0] IDX_COUNT = 10'd4;
  localparam logic [IDX_W-1:0] IDX_IEN   = 10'd5;
  localparam logic [IDX_W-1:0] IDX_STS   = 10'd6;
  localparam logic [IDX_W-1:0] IDX_FREQ  = 10'd7;

  typedef struct packed {
    logic run;
    logic mode;
    logic limit;
    logic count;
    logic ien;
    logic sts;
  } wr_strb_t;
endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter logic [DATA_W-1:0] ID_VALUE = '0,
  parameter logic [DATA_W-1:0] FREQ_HZ  = '1
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              we_i,
  input  logic              run_i,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] limit_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic              ien_i,
  input  logic              sts_i,
  output wr_strb_t          strb_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    strb_o       = '0;
    strb_o.run   = we_i && (idx_i == IDX_RUN);
    strb_o.mode  = we_i && (idx_i == IDX_MODE);
    strb_o.limit = we_i && (idx_i == IDX_LIMIT);
    strb_o.count = we_i && (idx_i == IDX_COUNT);
    strb_o.ien   = we_i && (idx_i == IDX_IEN);
    strb_o.sts   = we_i && (idx_i == IDX_STS);
  end

  always_comb begin
    rdata_o = '0;
    unique case (idx_i)
      IDX_ID:    rdata_o = ID_VALUE;
      IDX_RUN:   rdata_o[0] = run_i;
      IDX_MODE:  rdata_o[0] = mode_i;
      IDX_LIMIT: rdata_o = limit_i;
      IDX_COUNT: rdata_o = count_i;
      IDX_IEN:   rdata_o[0] = ien_i;
      IDX_STS:   rdata_o[0] = sts_i;
      IDX_FREQ:  rdata_o = FREQ_HZ;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_run_i,
  input  logic              we_mode_i,
  input  logic              we_limit_i,
  input  logic              we_count_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              run_o,
  output logic              mode_o,
  output logic [DATA_W-1:0] limit_o,
  output logic [DATA_W-1:0] count_o,
  output logic              expire_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic              run_q, run_d, mode_q, mode_d;
  logic [DATA_W-1:0] limit_q, limit_d, count_q, count_d;

  always_comb begin
    run_d    = run_q;
    mode_d   = mode_q;
    limit_d  = limit_q;
    count_d  = count_q;
    expire_o = 1'b0;
    if (run_q && tick_i) begin
      if (count_q == ONE) begin
        expire_o = 1'b1;
        if (mode_q) begin
          run_d   = 1'b0;
          count_d = '0;
        end else begin
          count_d = limit_q;
        end
      end else if (count_q == '0) begin
        count_d = limit_q;
      end else begin
        count_d = count_q - ONE;
      end
    end
    // bus writes override the tick update
    if (we_run_i) run_d = wdata_i[0];
    if (we_mode_i) begin
      mode_d = wdata_i[0];
      if (run_q) begin
        run_d   = 1'b1;
        count_d = limit_q;
      end
    end
    if (we_limit_i) begin
      limit_d = wdata_i;
      count_d = wdata_i;
    end
    if (we_count_i) count_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      mode_q  <= 1'b0;
      limit_q <= '0;
      count_q <= '0;
    end else begin
      run_q   <= run_d;
      mode_q  <= mode_d;
      limit_q <= limit_d;
      count_q <= count_d;
    end
  end

  assign run_o   = run_q;
  assign mode_o  = mode_q;
  assign limit_o = limit_q;
  assign count_o = count_q;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic we_ien_i,
  input  logic we_sts_i,
  input  logic wbit_i,
  output logic ien_o,
  output logic sts_o,
  output logic irq_o
);
  logic ien_q, sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      if (we_ien_i) ien_q <= wbit_i;
      // set from expiry beats write-one-to-clear
      if (expire_i)      sts_q <= 1'b1;
      else if (we_sts_i && wbit_i) sts_q <= 1'b0;
    end
  end

  assign ien_o = ien_q;
  assign sts_o = sts_q;
  assign irq_o = ien_q & sts_q;
endmodule

// File: rtl/tmr_interval_timer.sv
module tmr_interval_timer
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h7100_0A11,
  parameter logic [DATA_W-1:0] FREQ_HZ  = 32'd1_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [IDX_W-1:0]  bus_idx;
  logic              unused_addr;
  wr_strb_t          strb;
  logic              run_q, mode_q, ien_q, sts_q, expire;
  logic [DATA_W-1:0] limit_q, count_q;

  assign bus_idx     = bus_addr_i[11:2];
  assign unused_addr = ^{bus_addr_i[ADDR_W-1:12], bus_addr_i[1:0]};

  tmr_bus_decode #(
    .DATA_W(DATA_W), .ID_VALUE(ID_VALUE), .FREQ_HZ(FREQ_HZ)
  ) u_dec (
    .idx_i(bus_idx), .we_i(bus_we_i), .run_i(run_q), .mode_i(mode_q),
    .limit_i(limit_q), .count_i(count_q), .ien_i(ien_q), .sts_i(sts_q),
    .strb_o(strb), .rdata_o(bus_rdata_o)
  );

  tmr_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .we_run_i(strb.run), .we_mode_i(strb.mode), .we_limit_i(strb.limit),
    .we_count_i(strb.count), .wdata_i(bus_wdata_i),
    .run_o(run_q), .mode_o(mode_q), .limit_o(limit_q), .count_o(count_q),
    .expire_o(expire)
  );

  tmr_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .expire_i(expire),
    .we_ien_i(strb.ien), .we_sts_i(strb.sts), .wbit_i(bus_wdata_i[0]),
    .ien_o(ien_q), .sts_o(sts_q), .irq_o(irq_o)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              bus_we_i,
  input logic [9:0]        bus_idx,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              run_q,
  input logic              mode_q,
  input logic [DATA_W-1:0] limit_q,
  input logic [DATA_W-1:0] count_q,
  input logic              ien_q,
  input logic              sts_q,
  input logic              irq_o
);
  logic at_one, at_zero;
  assign at_one  = run_q && tick_i && (count_q == DATA_W'(1));
  assign at_zero = run_q && tick_i && (count_q == '0);

  AST_ONESHOT_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_one && mode_q && !bus_we_i |=> !run_q && (count_q == '0) && sts_q); // R5
  AST_PERIODIC_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_one && !mode_q && !bus_we_i |=> run_q && (count_q == $past(limit_q)) && sts_q); // R6
  AST_STOPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && !bus_we_i |=> $stable(count_q)); // R4
  AST_LIMIT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && (bus_idx == 10'd3) |=> (count_q == $past(bus_wdata_i)) && (limit_q == $past(bus_wdata_i))); // R7
  AST_ZERO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_zero && !bus_we_i |=> (count_q == $past(limit_q)) && $stable(sts_q)); // R13
  AST_STS_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && (bus_idx == 10'd6) && bus_wdata_i[0] && !at_one |=> !sts_q); // R11
  AST_IRQ_ENABLE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && (bus_idx == 10'd5) && bus_wdata_i[0] && sts_q |=> irq_o); // R10
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien_q |-> !irq_o); // R10
endmodule

bind tmr_interval_timer tmr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .bus_we_i(bus_we_i),
  .bus_idx(bus_idx), .bus_wdata_i(bus_wdata_i), .run_q(run_q), .mode_q(mode_q),
  .limit_q(limit_q), .count_q(count_q), .ien_q(ien_q), .sts_q(sts_q), .irq_o(irq_o)
);

// File: tb/sim_tmr_interval_timer.sv
`timescale 1ns/1ps
module sim_tmr_interval_timer;
  localparam logic [31:0] ID_V = 32'h7100_0A11;
  localparam logic [31:0] FQ_V = 32'd1_000_000;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0, rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0, cyc_n = 0;
  bit          done = 1'b0;

  // reference model
  logic        m_run, m_mode, m_ien, m_sts;
  logic [31:0] m_lim, m_cnt;

  always #2 clk = ~clk;

  tmr_interval_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] exp_rd(input logic [9:0] idx);
    case (idx)
      10'd0: return ID_V;
      10'd1: return {31'b0, m_run};
      10'd2: return {31'b0, m_mode};
      10'd3: return m_lim;
      10'd4: return m_cnt;
      10'd5: return {31'b0, m_ien};
      10'd6: return {31'b0, m_sts};
      10'd7: return FQ_V;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [9:0] idx);
    case (idx)
      10'd0, 10'd7: return "R2";
      10'd1: return "R3";
      10'd2: return "R9";
      10'd3: return "R7";
      10'd4: return "R4";
      10'd5: return "R10";
      10'd6: return "R11";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_run = 0; m_mode = 0; m_ien = 0; m_sts = 0; m_lim = '0; m_cnt = '0;
  endtask

  task automatic model_step(input logic w, input logic [9:0] idx, input logic [31:0] d, input logic t);
    logic        n_run = m_run, n_mode = m_mode, n_ien = m_ien, n_sts = m_sts, ex = 0;
    logic [31:0] n_lim = m_lim, n_cnt = m_cnt;
    if (m_run && t) begin
      if (m_cnt == 32'd1) begin
        ex = 1; n_sts = 1;
        if (m_mode) begin n_run = 0; n_cnt = 0; end else n_cnt = m_lim;
      end else if (m_cnt == 0) n_cnt = m_lim;
      else n_cnt = m_cnt - 1;
    end
    if (w) case (idx)
      10'd1: n_run = d[0];
      10'd2: begin n_mode = d[0]; if (m_run) begin n_run = 1; n_cnt = m_lim; end end
      10'd3: begin n_lim = d; n_cnt = d; end
      10'd4: n_cnt = d;
      10'd5: n_ien = d[0];
      10'd6: n_sts = (m_sts && !d[0]) || ex;
      default: ;
    endcase
    m_run = n_run; m_mode = n_mode; m_ien = n_ien; m_sts = n_sts; m_lim = n_lim; m_cnt = n_cnt;
  endtask

  // one bus cycle: drive, check reads and irq against model, advance model
  task automatic cyc(input logic w, input logic [9:0] idx, input logic [31:0] d,
                     input logic t, input logic [21:0] junk = '0);
    @(negedge clk);
    we = w; tick = t; wdata = d;
    addr = {junk[19:0], idx, junk[21:20]};
    #1;
    chk(tag_of(idx), rdata, exp_rd(idx));
    chk("R10", {31'b0, irq}, {31'b0, m_sts && m_ien});
    model_step(w, idx, d, t);
  endtask

  task automatic rd(input logic [9:0] idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    we = 0; tick = 0; wdata = '0; addr = {20'hABCDE, idx, 2'b11};
    #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc_n++;
      if (cyc_n > 150000 && !done) begin
        done = 1;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc_n);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(negedge clk);
    #1 chk("R12", {31'b0, irq}, 32'd0);
    rst_n = 1'b1;
    // R12 reset state
    for (int i = 1; i < 7; i++) rd(10'(i), 32'd0, "R12");
    rd(10'd0, ID_V, "R2");
    rd(10'd7, FQ_V, "R2");
    // R2 read-only words ignore writes
    cyc(1, 10'd0, 32'hFFFF_FFFF, 0);
    cyc(1, 10'd7, 32'h0, 0);
    rd(10'd0, ID_V, "R2");
    rd(10'd7, FQ_V, "R2");
    // R1 unmapped write ignored
    cyc(1, 10'd9, 32'hFFFF_FFFF, 0);
    rd(10'd9, 32'd0, "R1");
    rd(10'd3, 32'd0, "R1");
    // R7 limit loads count
    cyc(1, 10'd3, 32'd3, 0, 22'h3FFFFF);
    rd(10'd4, 32'd3, "R7");
    // R8 count write leaves limit
    cyc(1, 10'd4, 32'd5, 0);
    rd(10'd3, 32'd3, "R8");
    rd(10'd4, 32'd5, "R8");
    // R6 periodic expiry and reload
    cyc(1, 10'd5, 32'd1, 0);
    cyc(1, 10'd1, 32'd1, 0);
    repeat (5) cyc(0, 10'd4, 0, 1);
    rd(10'd4, 32'd3, "R6");
    rd(10'd6, 32'd1, "R5");
    chk("R10", {31'b0, irq}, 32'd1);
    // R11 write 0 keeps, write 1 clears
    cyc(1, 10'd6, 32'd0, 0);
    rd(10'd6, 32'd1, "R11");
    cyc(1, 10'd6, 32'd1, 0);
    rd(10'd6, 32'd0, "R11");
    chk("R10", {31'b0, irq}, 32'd0);
    // R9 mode change while running restarts count
    cyc(0, 10'd4, 0, 1);
    cyc(1, 10'd2, 32'd1, 1);
    rd(10'd4, 32'd3, "R9");
    rd(10'd1, 32'd1, "R9");
    // R5 single-shot expiry halts at zero
    repeat (3) cyc(0, 10'd4, 0, 1);
    rd(10'd1, 32'd0, "R5");
    rd(10'd4, 32'd0, "R5");
    // R3 same-value write, stop holds count
    cyc(1, 10'd1, 32'd0, 1);
    rd(10'd4, 32'd0, "R3");
    // R13 zero count running reloads without status
    cyc(1, 10'd6, 32'd1, 0);
    cyc(1, 10'd1, 32'd1, 0);
    cyc(0, 10'd4, 0, 1);
    rd(10'd4, 32'd3, "R13");
    rd(10'd6, 32'd0, "R13");
    // R14 bus write wins over tick
    cyc(1, 10'd4, 32'd40, 1);
    rd(10'd4, 32'd40, "R14");
    cyc(1, 10'd1, 32'd0, 0);
    cyc(1, 10'd1, 32'd0, 1);
    rd(10'd4, 32'd40, "R3");
    // seeded random traffic against the model
    for (int k = 0; k < 4000; k++) begin
      logic [9:0]  idx;
      logic [31:0] d;
      int unsigned r = $urandom % 12;
      idx = (r < 10) ? 10'(r) : 10'($urandom);
      d   = ($urandom % 4 == 0) ? $urandom : ($urandom % 8);
      cyc(($urandom % 3) == 0, idx, d, ($urandom % 2) == 0, 22'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule